// File: doc/BRIEF.md
# Response Ring Write Engine

This block takes 64-bit codec responses from a valid/ready input stream and writes each one into a circular buffer in system memory through a one-cycle write port. Every entry is a 32-bit response word and a 32-bit extended word. The extended word is stored without change, so its unsolicited-response flag and codec address reach software intact. The engine owns the ring's write pointer. Software reads the ring on its own and uses the write pointer to see how far the hardware has got.

Software configures the engine through a small register write port. The registers are a control word (run, interrupt enable), a ring size select, a write-pointer reset, a response threshold, a sticky status bit and a 64-bit ring base address. The engine counts stored responses. When the count reaches the threshold, it sets the status bit and restarts the count. The interrupt output is the status bit gated by the interrupt enable.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset, wrPtr is 0, rspStatus, irq, memWe and rspReady are 0, run and interrupt enable are off, the threshold is 0 and the size select is 0 (2 entries).
- R2: rspReady is 1 only while run (control register, address 0, bit 0) is 1 and the threshold (address 3, bits 7:0) is nonzero. It is 0 in every cycle in which cfgWe is high.
- R3: For each accepted response (rspValid and rspReady high at a clock edge), the pointer first advances to (wrPtr+1) mod depth. On that same edge memWe pulses for one cycle with memAddr = base + 8 × new pointer, and wrPtr shows the new pointer.
- R4: memData is {rspExt, rspWord}: the response word is in bits 31:0 and the extended word, including its unsolicited flag at bit 4, is in bits 63:32.
- R5: The size select register (address 1, bits 1:0) picks 2, 16 or 256 entries for the values 0, 1 and 2. A write of 3, or of a size missing from the capability mask, leaves the depth unchanged.
- R6: A write to address 2 with bit 15 set clears wrPtr to 0. A write to that address with bit 15 clear leaves wrPtr unchanged.
- R7: The base address is {high word (address 6), low word (address 5)}. Bits 6:0 of the low word are ignored, so the base is always 128-byte aligned.
- R8: When the count of stored responses reaches the threshold, rspStatus is set and the count restarts from 0. Writing the threshold also restarts the count.
- R9: rspStatus is sticky. Writing 1 to bit 0 of address 4 clears it, and writing 0 there leaves it set.
- R10: irq equals rspStatus ANDed with interrupt enable (address 0, bit 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgWdata | input | 32 | Register write data |
| rspValid | input | 1 | Response available |
| rspReady | output | 1 | Engine accepts a response this cycle |
| rspWord | input | 32 | Response payload word |
| rspExt | input | 32 | Extended word (unsolicited flag, codec address) |
| memWe | output | 1 | Memory write strobe, one cycle per entry |
| memAddr | output | 64 | Byte address of the entry |
| memData | output | 64 | Entry written to memory |
| wrPtr | output | 8 | Index of the most recently written entry |
| rspStatus | output | 1 | Sticky threshold-reached status |
| irq | output | 1 | Response interrupt |

## Verification
rspReady is combinational from the registers and cfgWe, so the bench checks it in the same cycle it drives the stimulus. Every other result appears one edge after the cause. A response accepted at an edge gives the memory write, the new pointer and any status change on that edge. A register write takes effect on its edge, and irq follows on the same edge because it is built from two registers. The bench drives inputs on the falling edge and samples at the next falling edge, exactly one rising edge later. Its expected values come from a reference model that uses a modulo depth and full-width address arithmetic.

// File: rtl/rring_pkg.sv
package rring_pkg;

  // Register map of the configuration write port
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_SIZE   = 3'd1,
    REG_WPTR   = 3'd2,
    REG_THRESH = 3'd3,
    REG_STAT   = 3'd4,
    REG_BASELO = 3'd5,
    REG_BASEHI = 3'd6
  } rringReg_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic store;
    logic ptrClr;
    logic baseLoWr;
    logic baseHiWr;
  } rringStb_t;

  localparam int unsigned PTR_RST_BIT = 15;
  localparam int unsigned ENTRY_SHIFT = 3;
  localparam int unsigned ALIGN_BITS  = 7;

endpackage

// File: rtl/rring_ctrl.sv
module rring_ctrl
  import rring_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter logic [2:0]  CAP   = 3'b111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [2:0]       cfgAddr,
  input  logic [15:0]      cfgWdata,
  input  logic             rspValid,
  output logic             rspReady,
  output rringStb_t        stb,
  output logic [1:0]       sizeSel,
  output logic             rspStatus,
  output logic             irq
);

  logic             runBit;
  logic             intEn;
  logic [CNT_W-1:0] threshQ;
  logic [CNT_W-1:0] storedCnt;
  logic [CNT_W:0]   storedNext;
  logic [3:0]       capExt;
  logic             accept;
  logic             reached;

  function automatic logic hit(input rringReg_e r);
    return cfgWe && (cfgAddr == r);
  endfunction

  assign capExt     = {1'b0, CAP};
  assign rspReady   = runBit && (threshQ != '0) && !cfgWe;
  assign accept     = rspValid && rspReady;
  assign storedNext = {1'b0, storedCnt} + 1'b1;
  assign reached    = storedNext >= {1'b0, threshQ};

  always_comb begin
    stb          = '0;
    stb.store    = accept;
    stb.ptrClr   = hit(REG_WPTR) && cfgWdata[PTR_RST_BIT];
    stb.baseLoWr = hit(REG_BASELO);
    stb.baseHiWr = hit(REG_BASEHI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runBit    <= 1'b0;
      intEn     <= 1'b0;
      sizeSel   <= 2'd0;
      threshQ   <= '0;
      storedCnt <= '0;
      rspStatus <= 1'b0;
    end else if (accept) begin
      if (reached) begin
        storedCnt <= '0;
        rspStatus <= 1'b1;
      end else begin
        storedCnt <= storedNext[CNT_W-1:0];
      end
    end else begin
      if (hit(REG_CTRL)) begin
        runBit <= cfgWdata[0];
        intEn  <= cfgWdata[1];
      end
      if (hit(REG_SIZE) && capExt[cfgWdata[1:0]])
        sizeSel <= cfgWdata[1:0];
      if (hit(REG_THRESH)) begin
        threshQ   <= cfgWdata[CNT_W-1:0];
        storedCnt <= '0;
      end
      if (hit(REG_STAT) && cfgWdata[0])
        rspStatus <= 1'b0;
    end
  end

  assign irq = rspStatus && intEn;

  // R2
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !runBit |-> !rspReady);

  // R2
  store_not_in_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.store |-> !cfgWe);

  // R8
  status_from_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rspStatus) |-> $past(stb.store));

endmodule

// File: rtl/rring_dp.sv
module rring_dp
  import rring_pkg::*;
#(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rringStb_t        stb,
  input  logic [1:0]       sizeSel,
  input  logic [31:0]      cfgWdata,
  input  logic [DW-1:0]    rspWord,
  input  logic [DW-1:0]    rspExt,
  output logic [PTR_W-1:0] wrPtr,
  output logic             memWe,
  output logic [63:0]      memAddr,
  output logic [2*DW-1:0]  memData
);

  localparam int unsigned HI_W = 32 - ALIGN_BITS;

  logic [HI_W-1:0]  baseLo;
  logic [31:0]      baseHi;
  logic [PTR_W-1:0] depthMask;
  logic [PTR_W-1:0] ptrInc;
  logic [63:0]      baseFull;

  always_comb begin
    unique case (sizeSel)
      2'd0:    depthMask = PTR_W'(1);
      2'd1:    depthMask = PTR_W'(15);
      default: depthMask = PTR_W'(255);
    endcase
  end

  assign ptrInc   = (wrPtr + 1'b1) & depthMask;
  assign baseFull = {baseHi, baseLo, {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
      baseLo  <= '0;
      baseHi  <= '0;
    end else begin
      memWe <= stb.store;
      if (stb.ptrClr)
        wrPtr <= '0;
      else if (stb.store)
        wrPtr <= ptrInc;
      if (stb.store) begin
        memAddr <= baseFull + (64'(ptrInc) << ENTRY_SHIFT);
        memData <= {rspExt, rspWord};
      end
      if (stb.baseLoWr) baseLo <= cfgWdata[31:ALIGN_BITS];
      if (stb.baseHiWr) baseHi <= cfgWdata;
    end
  end

  // R7
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (memAddr[ENTRY_SHIFT-1:0] == '0));

  // R3
  store_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.store |=> memWe);

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.store && !stb.ptrClr) |=> $stable(wrPtr));

endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
  import rring_pkg::*;
#(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned CNT_W = 8,
  parameter logic [2:0]  CAP   = 3'b111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [2:0]       cfgAddr,
  input  logic [31:0]      cfgWdata,
  input  logic             rspValid,
  output logic             rspReady,
  input  logic [31:0]      rspWord,
  input  logic [31:0]      rspExt,
  output logic             memWe,
  output logic [63:0]      memAddr,
  output logic [63:0]      memData,
  output logic [PTR_W-1:0] wrPtr,
  output logic             rspStatus,
  output logic             irq
);

  rringStb_t  stb;
  logic [1:0] sizeSel;

  rring_ctrl #(.CNT_W(CNT_W), .CAP(CAP)) uCtrl (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata[15:0]), .rspValid(rspValid), .rspReady(rspReady),
    .stb(stb), .sizeSel(sizeSel), .rspStatus(rspStatus), .irq(irq)
  );

  rring_dp #(.PTR_W(PTR_W), .DW(32)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sizeSel(sizeSel),
    .cfgWdata(cfgWdata), .rspWord(rspWord), .rspExt(rspExt),
    .wrPtr(wrPtr), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

endmodule

// File: tb/rsp_ring_writer_test.sv
module rsp_ring_writer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        rspValid = 1'b0;
  logic [31:0] rspWord = '0;
  logic [31:0] rspExt = '0;
  logic        rspReady, memWe, rspStatus, irq;
  logic [63:0] memAddr, memData;
  logic [7:0]  wrPtr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // reference model
  int unsigned mPtr = 0, mCnt = 0, mSel = 0, mThresh = 0;
  bit mRun = 0, mIntEn = 0, mStatus = 0;
  logic [31:0] mLo = '0, mHi = '0;

  always #2.5 clk = ~clk;

  rsp_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .rspValid(rspValid), .rspReady(rspReady),
    .rspWord(rspWord), .rspExt(rspExt), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .wrPtr(wrPtr), .rspStatus(rspStatus), .irq(irq)
  );

  function automatic int unsigned depthOf(int unsigned sel);
    return (sel == 0) ? 2 : (sel == 1) ? 16 : 256;
  endfunction

  function automatic logic [63:0] entryAddr(int unsigned idx);
    return {mHi, mLo[31:7], 7'b0} + 64'(idx) * 64'd8;
  endfunction

  function automatic bit expReady();
    return mRun && (mThresh != 0);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag);
    check(wrPtr == 8'(mPtr), {tag, " R3 ptr"}, 64'(wrPtr), 64'(mPtr));
    check(rspStatus == mStatus, {tag, " R8 status"}, 64'(rspStatus), 64'(mStatus));
    check(irq == (mStatus && mIntEn), {tag, " R10 irq"}, 64'(irq), 64'(mStatus && mIntEn));
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d; rspValid = 1'b1;
    #0.5;
    check(rspReady == 1'b0, "R2 ready low on cfg write", 64'(rspReady), 64'd0);
    @(negedge clk);
    cfgWe = 1'b0; rspValid = 1'b0;
    case (a)
      3'd0: begin mRun = d[0]; mIntEn = d[1]; end
      3'd1: if (d[1:0] != 2'd3) mSel = d[1:0];
      3'd2: if (d[15]) mPtr = 0;
      3'd3: begin mThresh = d[7:0]; mCnt = 0; end
      3'd4: if (d[0]) mStatus = 0;
      3'd5: mLo = d;
      3'd6: mHi = d;
      default: ;
    endcase
    check(memWe == 1'b0, "R2 no store on cfg write", 64'(memWe), 64'd0);
    checkState("cfg");
  endtask

  task automatic sendRsp(input logic [31:0] w, input logic [31:0] e);
    bit rdy;
    rdy = expReady();
    rspValid = 1'b1; rspWord = w; rspExt = e;
    #0.5;
    check(rspReady == rdy, "R2 ready", 64'(rspReady), 64'(rdy));
    @(negedge clk);
    rspValid = 1'b0;
    if (rdy) begin
      mPtr = (mPtr + 1) % depthOf(mSel);
      mCnt++;
      if (mCnt >= mThresh) begin mCnt = 0; mStatus = 1; end
      check(memWe == 1'b1, "R3 memWe", 64'(memWe), 64'd1);
      check(memAddr == entryAddr(mPtr), "R3 R7 addr", memAddr, entryAddr(mPtr));
      check(memData == {e, w}, "R4 data", memData, {e, w});
    end else begin
      check(memWe == 1'b0, "R2 no store", 64'(memWe), 64'd0);
    end
    checkState("rsp");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seedv;
    seedv = 32'h5EED1234;
    void'($urandom(seedv));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(wrPtr == 0 && rspStatus == 0 && irq == 0 && memWe == 0 && rspReady == 0,
          "R1 reset state", {wrPtr, rspStatus, irq, memWe, rspReady},
          64'd0);

    // directed: base with low bits set (R7), 16 entries (R5), threshold 3 (R8)
    cfgWrite(3'd5, 32'h1234_56FF);
    cfgWrite(3'd6, 32'h0000_0009);
    cfgWrite(3'd1, 32'd1);
    cfgWrite(3'd3, 32'd3);
    sendRsp(32'hAAAA_0001, 32'h0000_0010);   // stopped: R2
    cfgWrite(3'd0, 32'd3);
    for (int i = 0; i < 17; i++)
      sendRsp(32'hC0DE_0000 + i, (i % 2 == 1) ? 32'h0000_0010 : 32'h0000_0020);
    // R9: writing 0 keeps status, writing 1 clears
    cfgWrite(3'd4, 32'd0);
    cfgWrite(3'd4, 32'd1);
    // R6: no reset bit, then reset bit
    cfgWrite(3'd2, 32'h0000_7FFF);
    cfgWrite(3'd2, 32'h0000_8000);
    sendRsp(32'h1, 32'h2);
    // R5: size 3 ignored, then 2 entries, then 256
    cfgWrite(3'd1, 32'd3);
    sendRsp(32'h3, 32'h4);
    cfgWrite(3'd1, 32'd0);
    cfgWrite(3'd2, 32'h0000_8000);
    for (int i = 0; i < 3; i++) sendRsp(32'h50 + i, 32'h10);
    cfgWrite(3'd1, 32'd2);
    for (int i = 0; i < 5; i++) sendRsp(32'h60 + i, 32'h0);
    // R2: zero threshold blocks
    cfgWrite(3'd3, 32'd0);
    sendRsp(32'h77, 32'h0);
    // R10: enable off hides status
    cfgWrite(3'd3, 32'd1);
    cfgWrite(3'd0, 32'd1);
    sendRsp(32'h88, 32'h0);
    cfgWrite(3'd0, 32'd3);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int unsigned op;
      op = $urandom % 12;
      if (op < 8)
        sendRsp($urandom, $urandom);
      else if (op == 8)
        cfgWrite(3'd0, {30'd0, 1'b1, 1'($urandom % 4 != 0)} | 32'($urandom % 2) << 1);
      else if (op == 9)
        cfgWrite(3'd1, 32'($urandom % 4));
      else if (op == 10)
        cfgWrite(3'd3, 32'($urandom % 6));
      else
        cfgWrite(3'($urandom % 3 + 2), $urandom);
    end
    summary();
  end

endmodule